// File: doc/BRIEF.md
# Serial Wire Debug Host Transaction Engine

This block sits on the probe side of a two-wire debug link. It makes the serial debug clock itself from the system clock through a programmable half-period divider. It runs one debug-port or access-port register read or write per command on a bidirectional data pin, which is split into separate output, output-enable and input signals. A command carries the port select, the direction, a two-bit register address and 32 bits of write data. When the transaction ends, the block returns the target's acknowledge code, the read data and a parity-error flag through a valid/ready response handshake.

Every transaction starts with an 8-bit request and one turnaround cycle. A 3-bit acknowledge follows. After that comes a 33-bit data phase or an early end. The block drives its own bits when the debug clock falls. It samples target bits at the end of the low half, just before it raises the clock, because the target changes its bits right after each rising edge. The clock phase therefore differs between the send and receive phases. The divider input must be held steady while a transaction runs.

Top module: `swd_host_engine`

## Requirements
- R1: After reset, `swclk` is low, `swdio_oe` is 1 with `swdio_o` at 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: The request goes out LSB first as 8 bits. In sending order they are: 1, `cmd_ap`, `cmd_read`, `cmd_addr[0]`, `cmd_addr[1]`, the even parity of those four bits, 0, 1. A debug-port read of address 0 therefore sends the byte 0xA5.
- R3: `swdio_o` and `swdio_oe` change only in the system clock cycle where `swclk` falls, or while `swclk` stays low. They never change while `swclk` is high, and never when it rises.
- R4: Target bits are sampled at the last system clock of the low half, before `swclk` rises. A target that changes its bit right after a rising edge is read correctly.
- R5: Each `swclk` high half lasts exactly `max(half_div,1)` system clocks. Within a transaction, consecutive rising edges are `2*max(half_div,1)` system clocks apart.
- R6: After the request, `swdio_oe` is 0 for one turnaround cycle. The 3-bit acknowledge is then sampled LSB first and reported on `rsp_ack`, where OK is 3'b001, WAIT is 3'b010 and FAULT is 3'b100.
- R7: On a read with OK, 32 data bits are sampled LSB first and then a parity bit. `rsp_rdata` carries the data. `rsp_perr` is 1 exactly when the parity bit differs from the even parity of the data. One released turnaround cycle follows, for 46 clock cycles in total.
- R8: On a write with OK, one released turnaround cycle follows the acknowledge. The block then drives the 32 data bits LSB first and then their even parity, for 46 clock cycles in total.
- R9: On any acknowledge other than OK, the transaction ends after one released turnaround cycle, for 13 clock cycles in total. `rsp_rdata` and `rsp_perr` are 0. Write responses also report 0 on both.
- R10: A command is taken when `cmd_valid` and `cmd_ready` are both high. The response stays valid and unchanged until `rsp_ready` is high. `cmd_ready` and `rsp_valid` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| half_div | input | DIV_W | Debug clock half-period in system clocks (0 acts as 1) |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command accepted |
| cmd_ap | input | 1 | 1 selects an access port, 0 the debug port |
| cmd_read | input | 1 | 1 for read, 0 for write |
| cmd_addr | input | 2 | Register address bits 3:2 |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Response consumed |
| rsp_ack | output | 3 | Acknowledge received from the target |
| rsp_rdata | output | 32 | Read data (0 unless read with OK) |
| rsp_perr | output | 1 | Read data parity mismatch |
| swclk | output | 1 | Debug clock to target |
| swdio_o | output | 1 | Data pin output value |
| swdio_oe | output | 1 | Data pin output enable |
| swdio_i | input | 1 | Data pin input value |

## Verification
The bench's target model changes its data bit one nanosecond after each rising debug clock edge. An engine that sampled on or after the rise would read every acknowledge and data bit shifted by one position. The sweep covers all sixteen request encodings at four divider settings, including divider 0. A wrong parity or field order shows up as a wrong request byte. An off-by-one in the divider shows up as wrong high-phase or period lengths. Reads carry injected parity errors, and WAIT, FAULT and no-response acknowledges are mixed in. A design that ran the data phase regardless of the acknowledge would show the wrong clock cycle count. A missed turnaround would be caught by the output-enable checks at the turnaround edges.

// File: rtl/swd_host_engine.sv
module swd_host_engine #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] half_div,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic             cmd_ap,
  input  logic             cmd_read,
  input  logic [1:0]       cmd_addr,
  input  logic [31:0]      cmd_wdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [2:0]       rsp_ack,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_perr,
  output logic             swclk,
  output logic             swdio_o,
  output logic             swdio_oe,
  input  logic             swdio_i
);

  localparam logic [2:0] ACK_OK = 3'b001;
  localparam int WORD_BITS = 33;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_TRN_A, S_ACK, S_RDAT, S_TRN_W, S_WDAT, S_TRN_E, S_RESP
  } st_t;

  st_t                  st;
  logic [DIV_W-1:0]     cnt;
  logic                 ph;
  logic [5:0]           bcnt;
  logic [7:0]           req_sr;
  logic [WORD_BITS-1:0] tx, rx;
  logic [2:0]           ack_q;
  logic                 rd_q, clk_q, o_q, oe_q;

  wire [DIV_W-1:0] half     = (half_div == '0) ? DIV_W'(1) : half_div;
  wire             tick     = (cnt == half - DIV_W'(1));
  wire             sample   = (st == S_ACK) || (st == S_RDAT);
  wire             req_par  = cmd_ap ^ cmd_read ^ cmd_addr[0] ^ cmd_addr[1];
  wire [2:0]       ack_in   = rx[WORD_BITS-1 -: 3];
  wire             rd_ok    = rd_q && (ack_q == ACK_OK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      cnt    <= '0;
      ph     <= 1'b0;
      bcnt   <= '0;
      req_sr <= '0;
      tx     <= '0;
      rx     <= '0;
      ack_q  <= '0;
      rd_q   <= 1'b0;
      clk_q  <= 1'b0;
      o_q    <= 1'b0;
      oe_q   <= 1'b1;
    end else begin
      case (st)
        S_IDLE: if (cmd_valid) begin
          req_sr <= {1'b1, 1'b0, req_par, cmd_addr[1], cmd_addr[0], cmd_read, cmd_ap, 1'b1};
          tx     <= {^cmd_wdata, cmd_wdata};
          rd_q   <= cmd_read;
          ack_q  <= '0;
          o_q    <= 1'b1;
          oe_q   <= 1'b1;
          bcnt   <= '0;
          cnt    <= '0;
          ph     <= 1'b0;
          st     <= S_REQ;
        end
        S_RESP: if (rsp_ready) st <= S_IDLE;
        default: begin
          if (!tick) begin
            cnt <= cnt + DIV_W'(1);
          end else begin
            cnt <= '0;
            if (!ph) begin
              ph    <= 1'b1;
              clk_q <= 1'b1;
              if (sample) rx <= {swdio_i, rx[WORD_BITS-1:1]};
            end else begin
              ph    <= 1'b0;
              clk_q <= 1'b0;
              bcnt  <= bcnt + 6'd1;
              case (st)
                S_REQ: begin
                  req_sr <= req_sr >> 1;
                  o_q    <= req_sr[1];
                  if (bcnt == 6'd7) begin
                    oe_q <= 1'b0;
                    bcnt <= '0;
                    st   <= S_TRN_A;
                  end
                end
                S_TRN_A: begin
                  bcnt <= '0;
                  st   <= S_ACK;
                end
                S_ACK: if (bcnt == 6'd2) begin
                  ack_q <= ack_in;
                  bcnt  <= '0;
                  if (ack_in != ACK_OK) st <= S_TRN_E;
                  else if (rd_q)        st <= S_RDAT;
                  else                  st <= S_TRN_W;
                end
                S_RDAT: if (bcnt == 6'(WORD_BITS - 1)) begin
                  bcnt <= '0;
                  st   <= S_TRN_E;
                end
                S_TRN_W: begin
                  oe_q <= 1'b1;
                  o_q  <= tx[0];
                  tx   <= tx >> 1;
                  bcnt <= '0;
                  st   <= S_WDAT;
                end
                S_WDAT: begin
                  if (bcnt == 6'(WORD_BITS - 1)) begin
                    o_q <= 1'b0;
                    st  <= S_RESP;
                  end else begin
                    o_q <= tx[0];
                    tx  <= tx >> 1;
                  end
                end
                S_TRN_E: begin
                  oe_q <= 1'b1;
                  o_q  <= 1'b0;
                  st   <= S_RESP;
                end
                default: st <= S_IDLE;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign cmd_ready = (st == S_IDLE);
  assign rsp_valid = (st == S_RESP);
  assign rsp_ack   = ack_q;
  assign rsp_rdata = rd_ok ? rx[31:0] : 32'd0;
  assign rsp_perr  = rd_ok & (^rx);
  assign swclk     = clk_q;
  assign swdio_o   = o_q;
  assign swdio_oe  = oe_q;

endmodule

// File: rtl/swd_host_engine_chk.sv
module swd_host_engine_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] half_div,
  input logic             cmd_ready,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [2:0]       rsp_ack,
  input logic [31:0]      rsp_rdata,
  input logic             rsp_perr,
  input logic             swclk,
  input logic             swdio_o,
  input logic             swdio_oe
);

  logic        swclk_d;
  logic [15:0] run;
  wire  [15:0] half_eff = (half_div == '0) ? 16'd1 : 16'(half_div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swclk_d <= 1'b0;
      run     <= '0;
    end else begin
      swclk_d <= swclk;
      if (swclk != swclk_d) run <= 16'd1;
      else if (run != 16'hFFFF) run <= run + 16'd1;
    end
  end

  a_r1_idle_clock_low: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!swclk && swdio_oe));

  a_r3_stable_while_high: assert property (@(posedge clk) disable iff (!rst_n)
    swclk |-> ($stable(swdio_o) && $stable(swdio_oe)));

  a_r5_min_half_period: assert property (@(posedge clk) disable iff (!rst_n)
    (swclk != swclk_d) |-> (run >= half_eff));

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_ack) && $stable(rsp_rdata) && $stable(rsp_perr)));

  a_r10_ready_valid_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_ready && rsp_valid));

endmodule

bind swd_host_engine swd_host_engine_chk #(.DIV_W(DIV_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .half_div  (half_div),
  .cmd_ready (cmd_ready),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_ack   (rsp_ack),
  .rsp_rdata (rsp_rdata),
  .rsp_perr  (rsp_perr),
  .swclk     (swclk),
  .swdio_o   (swdio_o),
  .swdio_oe  (swdio_oe)
);

// File: tb/swd_host_engine_tb.sv
`timescale 1ns/1ps
module swd_host_engine_tb;

  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [DIV_W-1:0] half_div = '0;
  logic             cmd_valid = 1'b0, cmd_ap = 1'b0, cmd_read = 1'b0;
  logic [1:0]       cmd_addr = '0;
  logic [31:0]      cmd_wdata = '0;
  logic             rsp_ready = 1'b0;
  logic             swdio_i = 1'b0;
  logic             cmd_ready, rsp_valid, rsp_perr, swclk, swdio_o, swdio_oe;
  logic [2:0]       rsp_ack;
  logic [31:0]      rsp_rdata;

  always #2.5 clk = ~clk;

  swd_host_engine #(.DIV_W(DIV_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_ap(cmd_ap), .cmd_read(cmd_read),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_ack(rsp_ack),
    .rsp_rdata(rsp_rdata), .rsp_perr(rsp_perr),
    .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // target model state
  int          edge_n = 0;
  logic [2:0]  tgt_ack = 3'b001;
  logic        tgt_rnw = 1'b0;
  logic [32:0] tgt_word = '0;
  logic [7:0]  req_seen;
  logic [32:0] wr_seen;
  bit          oe_bad, stab_bad, tim_bad;
  int          hval = 1;

  wire tgt_ok = (tgt_ack == 3'b001);

  always @(posedge swclk) begin
    int e;
    e = edge_n;
    edge_n++;
    if (e < 8) begin
      req_seen[e] = swdio_o;
      if (!swdio_oe) oe_bad = 1'b1;
    end
    if (e == 8 && swdio_oe) oe_bad = 1'b1;
    if (!tgt_ok && e == 12 && swdio_oe) oe_bad = 1'b1;
    if (tgt_ok && tgt_rnw && e == 45 && swdio_oe) oe_bad = 1'b1;
    if (tgt_ok && !tgt_rnw && e == 12 && swdio_oe) oe_bad = 1'b1;
    if (tgt_ok && !tgt_rnw && e >= 13 && e <= 45) begin
      wr_seen[e-13] = swdio_o;
      if (!swdio_oe) oe_bad = 1'b1;
    end
    #1;
    if (e >= 8 && e <= 10) swdio_i = tgt_ack[e-8];
    else if (tgt_ok && tgt_rnw && e >= 11 && e <= 43) swdio_i = tgt_word[e-11];
    else swdio_i = 1'b1;
  end

  logic p_clk = 1'b0, p_o = 1'b0, p_oe = 1'b1;
  int   hi_len = 0, per = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (swclk && (swdio_o != p_o || swdio_oe != p_oe)) stab_bad = 1'b1;
      if (swclk && !p_clk) begin
        if (edge_n > 1 && per != 2*hval) tim_bad = 1'b1;
        per = 1;
        hi_len = 1;
      end else begin
        per++;
        if (!swclk && p_clk && hi_len != hval) tim_bad = 1'b1;
        if (swclk) hi_len++;
      end
    end
    p_clk = swclk;
    p_o   = swdio_o;
    p_oe  = swdio_oe;
  end

  task automatic run_txn(input logic ap, input logic rnw, input logic [1:0] addr,
                         input logic [31:0] data, input logic [2:0] ack, input bit bad_par);
    logic [7:0] exp_req;
    logic       ok, exp_perr;
    logic [31:0] exp_rd;
    int          exp_edges;
    logic [2:0]  ack_hold;
    ok = (ack == 3'b001);
    exp_req = {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
    tgt_ack  = ack;
    tgt_rnw  = rnw;
    tgt_word = {(^data) ^ bad_par, data};
    edge_n = 0; oe_bad = 0; stab_bad = 0; tim_bad = 0;
    hval = (half_div == 0) ? 1 : int'(half_div);
    @(negedge clk);
    chk(cmd_ready, "R10", "cmd_ready before command", 64'(cmd_ready), 64'd1);
    cmd_ap = ap; cmd_read = rnw; cmd_addr = addr; cmd_wdata = data; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    exp_edges = ok ? 46 : 13;
    exp_rd    = (ok && rnw) ? data : 32'd0;
    exp_perr  = ok && rnw && bad_par;
    chk(req_seen == exp_req, "R2", "request byte", 64'(req_seen), 64'(exp_req));
    chk(rsp_ack == ack, "R6", "acknowledge", 64'(rsp_ack), 64'(ack));
    chk(rsp_rdata == exp_rd, ok ? "R7" : "R9", "read data", 64'(rsp_rdata), 64'(exp_rd));
    chk(rsp_perr == exp_perr, ok ? "R7" : "R9", "parity flag", 64'(rsp_perr), 64'(exp_perr));
    chk(edge_n == exp_edges, ok ? (rnw ? "R7" : "R8") : "R9", "clock cycle count",
        64'(edge_n), 64'(exp_edges));
    chk(!oe_bad, "R6", "output enable at turnaround/drive edges", 64'(oe_bad), 64'd0);
    chk(!stab_bad, "R3", "outputs changed while clock high", 64'(stab_bad), 64'd0);
    chk(!tim_bad, "R5", "half-period timing", 64'(tim_bad), 64'd0);
    if (ok && !rnw)
      chk(wr_seen == {^data, data}, "R8", "write bits on wire", 64'(wr_seen), 64'({^data, data}));
    ack_hold = rsp_ack;
    @(negedge clk);
    chk(rsp_valid && rsp_ack == ack_hold, "R10", "response held without ready",
        64'(rsp_valid), 64'd1);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(cmd_ready && !rsp_valid, "R10", "return to idle after ready",
        64'({cmd_ready, rsp_valid}), 64'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!swclk && swdio_oe && !swdio_o && cmd_ready && !rsp_valid, "R1", "reset state",
        64'({swclk, swdio_oe, swdio_o, cmd_ready, rsp_valid}), 64'b01010);

    half_div = 8'd1;
    run_txn(1'b0, 1'b1, 2'b00, 32'h2BA01477, 3'b001, 1'b0);
    chk(req_seen == 8'hA5, "R2", "debug-port read of address 0 byte", 64'(req_seen), 64'hA5);

    for (int d = 0; d < 4; d++) begin
      half_div = DIV_W'(d);
      for (int r = 0; r < 16; r++) begin
        logic [31:0] pat;
        pat = (32'h9E3779B9 * 32'(r + 1)) ^ (32'h01010101 * 32'(d)) ^ 32'h80000001;
        // R4: target changes bits right after each rise; the values here only match when sampled before the rise
        run_txn(r[0], r[1], 2'(r >> 2), pat, 3'b001, r[0] ^ d[0]);
      end
    end

    half_div = 8'd2;
    run_txn(1'b1, 1'b1, 2'b01, 32'hFFFF0000, 3'b010, 1'b0);   // R9 WAIT on read
    run_txn(1'b0, 1'b0, 2'b10, 32'h12345678, 3'b100, 1'b0);   // R9 FAULT on write
    run_txn(1'b1, 1'b1, 2'b11, 32'hA5A5A5A5, 3'b111, 1'b1);   // R9 no response
    half_div = 8'd3;
    run_txn(1'b0, 1'b1, 2'b11, 32'h00000000, 3'b001, 1'b1);   // R7 zero data, bad parity
    run_txn(1'b1, 1'b1, 2'b10, 32'hFFFFFFFF, 3'b001, 1'b0);   // R7 all ones
    run_txn(1'b1, 1'b0, 2'b01, 32'hFFFFFFFF, 3'b001, 1'b0);   // R8 all ones write

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule